// File: doc/BRIEF.md
# Fractional-Ratio Receive Clock Synthesizer

This block produces a receive clock from a free-running reference clock in the 60 to 80 MHz range. The reference needs no fixed phase or frequency relation to the clock it produces. The output toggles once per half-period. Each half-period lasts a programmable ratio of reference cycles: an integer part plus a 16-bit fraction. The output frequency is therefore the reference frequency divided by twice that ratio. A fractional accumulator adds the fraction once per half-period, and each carry out of it stretches that half-period by one reference cycle.

A byte-wide write-only register port holds the integer factor, the two bytes of the fraction, a 7-bit loop gain and an 8-bit initial value for the phase detector. The same port also takes a strobe that returns the phase detector to that initial value. The phase detector accepts signed phase-error samples over a valid/ready stream. It is paced by a slower general clock, which is made inside the block as a one-cycle enable every `SCALE` reference cycles. The detector's saturated phase value is multiplied by the gain and bounded. The result trims the ratio up or down in units of 1/65536 of a reference cycle. The logic that derives phase error from line data lives outside this block.

Top module: `frac_clk_synth`

## Requirements
- R1: While `rst` is high, `rclk_out` is low. After reset the integer factor is 2, the fraction is 0, the gain is 0 and the phase value is 0, so every half-period lasts exactly 2 reference cycles.
- R2: Each half-period lasts I or I+1 reference cycles, where I is the integer factor. Over N consecutive half-periods, with N·F a multiple of 65536, the total is exactly N·I + N·F/65536 cycles, where F is the effective 16-bit fraction.
- R3: An integer factor of 0 or 1 acts as 2. The effective ratio, after trim, never drops below 2.0, so no half-period is shorter than 2 cycles.
- R4: A write to address 0xD5 only stages the fraction low byte and has no effect on the output. A write to 0xD6 commits the fraction atomically as {0xD6 data, staged low byte}.
- R5: A ratio change is sampled only at a half-period boundary. The half-period already running keeps its length, and the next one uses the new ratio.
- R6: Address 0xD7 holds the integer factor. Address 0xD8 holds the gain in data bits [6:0]. Address 0xDB holds the signed initial phase value. Any write to 0xF6 loads the phase value from the initial value, and its data is ignored.
- R7: `err_ready` is high for exactly one reference cycle in every `SCALE` (6 by default). A sample is taken when `err_valid` and `err_ready` are both high. The signed 8-bit sample is added to the phase value, which saturates at +127 and -128.
- R8: The trim equals phase × gain, bounded to ±4096, and is added to the ratio in units of 2^-16 of a cycle. For example, a phase of 16 with a gain of 64 lengthens the ratio by 1024/65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| err_valid | input | 1 | Phase-error sample valid |
| err_ready | output | 1 | Phase detector takes a sample this cycle |
| err_data | input | 8 | Signed phase-error sample |
| rclk_out | output | 1 | Synthesized receive clock |

## Verification
A register write lands at the clock edge that follows it. It reaches the output only at the next half-period boundary, so a change can show up as late as 255 cycles after the write. The reset strobe sets the phase value one edge after the register captures it, and the trim follows one edge later. The bench therefore lets three output toggles pass after any programming before it measures intervals. Edge times are sampled on the falling reference edge, and the boundary test writes right after a toggle so that the running and the following half-period can each be measured exactly. Interval totals are compared only over windows in which the count of fractional carries does not depend on the accumulator's starting value; where it does, the check accepts a stated range.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int FRAC_W  = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] A_FRAC_LO = 8'hD5;
  localparam logic [ADDR_W-1:0] A_FRAC_HI = 8'hD6;
  localparam logic [ADDR_W-1:0] A_FACTOR  = 8'hD7;
  localparam logic [ADDR_W-1:0] A_GAIN    = 8'hD8;
  localparam logic [ADDR_W-1:0] A_PH_INIT = 8'hDB;
  localparam logic [ADDR_W-1:0] A_PH_LOAD = 8'hF6;
endpackage

// File: rtl/synth_regs.sv
module synth_regs
  import synth_pkg::*;
#(
  parameter int FAC_W   = 8,
  parameter int GAIN_W  = 7,
  parameter int PH_W    = 8,
  parameter int RST_FAC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [FAC_W-1:0]  factor,
  output logic [FRAC_W-1:0] frac,
  output logic [GAIN_W-1:0] gain,
  output logic [PH_W-1:0]   ph_init,
  output logic              ph_load
);
  logic [DATA_W-1:0] lo_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      factor   <= FAC_W'(RST_FAC);
      frac     <= '0;
      gain     <= '0;
      ph_init  <= '0;
      lo_stage <= '0;
      ph_load  <= 1'b0;
    end else begin
      ph_load <= wr_en && (wr_addr == A_PH_LOAD);
      if (wr_en) begin
        case (wr_addr)
          A_FRAC_LO: lo_stage <= wr_data;
          A_FRAC_HI: frac     <= {wr_data, lo_stage};
          A_FACTOR:  factor   <= FAC_W'(wr_data);
          A_GAIN:    gain     <= wr_data[GAIN_W-1:0];
          A_PH_INIT: ph_init  <= PH_W'(wr_data);
          default: ;
        endcase
      end
    end
  end

  // R4: a low-byte write alone leaves the committed fraction untouched
  assert_lo_stage_only_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_FRAC_LO) |=> $stable(frac));

  // R4: the high-byte write commits both bytes together
  assert_atomic_commit_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_FRAC_HI) |=> frac == {$past(wr_data), $past(lo_stage)});
endmodule

// File: rtl/synth_phase.sv
module synth_phase #(
  parameter int PH_W     = 8,
  parameter int GAIN_W   = 7,
  parameter int SCALE    = 6,
  parameter int TRIM_MAX = 4096,
  parameter int TRIM_W   = $clog2(TRIM_MAX) + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ph_load,
  input  logic [PH_W-1:0]          ph_init,
  input  logic [GAIN_W-1:0]        gain,
  input  logic                     err_valid,
  output logic                     err_ready,
  input  logic [PH_W-1:0]          err_data,
  output logic signed [TRIM_W-1:0] trim
);
  localparam int DIV_W = (SCALE > 1) ? $clog2(SCALE) : 1;
  localparam int P_W   = PH_W + GAIN_W + 1;
  localparam logic signed [PH_W:0]  PH_HI = (PH_W+1)'((1 << (PH_W-1)) - 1);
  localparam logic signed [PH_W:0]  PH_LO = -PH_HI - 1;
  localparam logic signed [P_W-1:0] T_HI  = P_W'(TRIM_MAX);
  localparam logic signed [P_W-1:0] T_LO  = -T_HI;

  logic [DIV_W-1:0]        gdiv;
  logic signed [PH_W-1:0]  phase;
  logic signed [PH_W:0]    ph_sum;
  logic signed [P_W-1:0]   prod;
  logic signed [P_W-1:0]   prod_b;
  logic                    take;

  // general-clock enable derived from the reference
  always_ff @(posedge clk) begin
    if (rst || gdiv == DIV_W'(SCALE - 1)) gdiv <= '0;
    else                                  gdiv <= gdiv + 1'b1;
  end
  assign err_ready = (gdiv == DIV_W'(SCALE - 1));
  assign take      = err_valid && err_ready;

  assign ph_sum = {phase[PH_W-1], phase} + {err_data[PH_W-1], err_data};

  always_ff @(posedge clk) begin
    if (rst)          phase <= '0;
    else if (ph_load) phase <= ph_init;
    else if (take) begin
      if (ph_sum > PH_HI)      phase <= PH_HI[PH_W-1:0];
      else if (ph_sum < PH_LO) phase <= PH_LO[PH_W-1:0];
      else                     phase <= ph_sum[PH_W-1:0];
    end
  end

  assign prod = P_W'(phase) * $signed({1'b0, gain});

  always_comb begin
    if (prod > T_HI)      prod_b = T_HI;
    else if (prod < T_LO) prod_b = T_LO;
    else                  prod_b = prod;
  end

  always_ff @(posedge clk) begin
    if (rst) trim <= '0;
    else     trim <= prod_b[TRIM_W-1:0];
  end

  // R6: the load strobe presets the phase from the init register
  assert_load_init_R6: assert property (@(posedge clk) disable iff (rst)
    ph_load |=> phase == $past(ph_init));

  // R7: the detector enable is a single-cycle pulse
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    err_ready |=> !err_ready);

  // R7: without a load or an accepted sample the phase holds
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ph_load && !take) |=> $stable(phase));

  // R8: the applied trim stays inside its bound
  assert_trim_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (trim <= TRIM_W'(TRIM_MAX)) && (trim >= -TRIM_W'(TRIM_MAX)));
endmodule

// File: rtl/synth_fdiv.sv
module synth_fdiv #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  ratio_int,
  input  logic [FRAC_W-1:0] ratio_frac,
  output logic              clk_out
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W-1:0] acc_n;
  logic              carry;
  logic              edge_now;

  assign {carry, acc_n} = {1'b0, acc} + {1'b0, ratio_frac};
  assign edge_now       = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= CNT_W'(1);
      acc     <= '0;
      clk_out <= 1'b0;
    end else if (edge_now) begin
      clk_out <= ~clk_out;
      acc     <= acc_n;
      cnt     <= {1'b0, ratio_int} + CNT_W'(carry);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R3: every half-period loaded is at least two cycles long
  assert_len_floor_R3: assert property (@(posedge clk) disable iff (rst)
    edge_now |=> cnt >= CNT_W'(2));

  // R5: between boundaries the output holds and the count only runs down
  assert_mid_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !edge_now |=> ($stable(clk_out) && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/frac_clk_synth.sv
module frac_clk_synth
  import synth_pkg::*;
#(
  parameter int FAC_W    = 8,
  parameter int GAIN_W   = 7,
  parameter int PH_W     = 8,
  parameter int SCALE    = 6,
  parameter int TRIM_MAX = 4096,
  parameter int MIN_FAC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_valid,
  output logic              err_ready,
  input  logic [PH_W-1:0]   err_data,
  output logic              rclk_out
);
  localparam int TRIM_W = $clog2(TRIM_MAX) + 2;
  localparam int RAT_W  = FAC_W + FRAC_W;
  localparam int SUM_W  = RAT_W + 2;
  localparam logic signed [SUM_W-1:0] LO_LIM = SUM_W'(MIN_FAC) <<< FRAC_W;
  localparam logic signed [SUM_W-1:0] HI_LIM = (SUM_W'(1) <<< RAT_W) - 1'b1;

  logic [FAC_W-1:0]          factor;
  logic [FAC_W-1:0]          fac_c;
  logic [FRAC_W-1:0]         frac;
  logic [GAIN_W-1:0]         gain;
  logic [PH_W-1:0]           ph_init;
  logic                      ph_load;
  logic signed [TRIM_W-1:0]  trim;
  logic signed [SUM_W-1:0]   eff;
  logic [RAT_W-1:0]          ratio;

  synth_regs #(
    .FAC_W(FAC_W), .GAIN_W(GAIN_W), .PH_W(PH_W), .RST_FAC(MIN_FAC)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .factor(factor), .frac(frac), .gain(gain), .ph_init(ph_init), .ph_load(ph_load)
  );

  synth_phase #(
    .PH_W(PH_W), .GAIN_W(GAIN_W), .SCALE(SCALE), .TRIM_MAX(TRIM_MAX), .TRIM_W(TRIM_W)
  ) u_phase (
    .clk(clk), .rst(rst), .ph_load(ph_load), .ph_init(ph_init), .gain(gain),
    .err_valid(err_valid), .err_ready(err_ready), .err_data(err_data), .trim(trim)
  );

  // factor clamp, signed trim, then floor/ceiling on the whole ratio
  assign fac_c = (factor < FAC_W'(MIN_FAC)) ? FAC_W'(MIN_FAC) : factor;
  assign eff   = $signed({2'b00, fac_c, frac})
               + {{(SUM_W-TRIM_W){trim[TRIM_W-1]}}, trim};

  always_comb begin
    if (eff < LO_LIM)      ratio = LO_LIM[RAT_W-1:0];
    else if (eff > HI_LIM) ratio = HI_LIM[RAT_W-1:0];
    else                   ratio = eff[RAT_W-1:0];
  end

  synth_fdiv #(.INT_W(FAC_W), .FRAC_W(FRAC_W)) u_fdiv (
    .clk(clk), .rst(rst),
    .ratio_int(ratio[RAT_W-1:FRAC_W]), .ratio_frac(ratio[FRAC_W-1:0]),
    .clk_out(rclk_out)
  );

  // R3: the integer part handed to the divider never falls below the floor
  assert_ratio_floor_R3: assert property (@(posedge clk) disable iff (rst)
    ratio[RAT_W-1:FRAC_W] >= FAC_W'(MIN_FAC));

  // R1: the output stays low while reset is held
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !rclk_out);
endmodule

// File: tb/frac_clk_synth_tb.sv
module frac_clk_synth_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       err_valid = 1'b0;
  logic       err_ready;
  logic [7:0] err_data = '0;
  logic       rclk_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_clk_synth u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_valid(err_valid), .err_ready(err_ready), .err_data(err_data),
    .rclk_out(rclk_out)
  );

  // {factor, frac_hi, frac_lo, gain, init, count16, total16}
  localparam int NV = 11;
  localparam logic [71:0] VEC [NV] = '{
    {8'd4,   8'h00, 8'h00, 8'd0,   8'h00, 16'd8,  16'd32},   // R2 integer only
    {8'd5,   8'h80, 8'h00, 8'd0,   8'h00, 16'd8,  16'd44},   // R2 half
    {8'd3,   8'h40, 8'h00, 8'd0,   8'h00, 16'd8,  16'd26},   // R2 quarter
    {8'd0,   8'h00, 8'h00, 8'd0,   8'h00, 16'd8,  16'd16},   // R3 factor 0
    {8'd1,   8'h80, 8'h00, 8'd0,   8'h00, 16'd4,  16'd10},   // R3 factor 1
    {8'd4,   8'h00, 8'h00, 8'd64,  8'h10, 16'd64, 16'd257},  // R8 +1024
    {8'd4,   8'h00, 8'h00, 8'd64,  8'hF0, 16'd64, 16'd255},  // R8 -1024
    {8'd4,   8'h00, 8'h00, 8'd127, 8'h7F, 16'd16, 16'd65},   // R8 clamp +
    {8'd4,   8'h00, 8'h00, 8'd127, 8'h80, 16'd16, 16'd63},   // R8 clamp -
    {8'd255, 8'hC0, 8'h00, 8'd0,   8'h00, 16'd4,  16'd1023}, // R2 max factor
    {8'd2,   8'h00, 8'h00, 8'd64,  8'hF0, 16'd8,  16'd16}    // R3 floor after trim
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic next_edge(output int t);
    logic p;
    p = rclk_out;
    do @(negedge clk); while (rclk_out == p);
    t = cyc;
  endtask

  task automatic measure(input int n, output int total, output int mn, output int mx);
    int t0, t1, d;
    total = 0; mn = 1 << 30; mx = 0;
    next_edge(t0);
    for (int i = 0; i < n; i++) begin
      next_edge(t1);
      d = t1 - t0;
      total += d;
      if (d < mn) mn = d;
      if (d > mx) mx = d;
      t0 = t1;
    end
  endtask

  task automatic settle();
    int t;
    for (int i = 0; i < 3; i++) next_edge(t);
  endtask

  task automatic prog(input logic [7:0] f, input logic [7:0] hi, input logic [7:0] lo,
                      input logic [7:0] g, input logic [7:0] ini);
    wr(8'hD5, lo);
    wr(8'hD6, hi);
    wr(8'hD7, f);
    wr(8'hD8, g);
    wr(8'hDB, ini);
    wr(8'hF6, 8'hA5);
    settle();
  endtask

  task automatic send_err(input logic [7:0] e);
    @(negedge clk);
    err_valid = 1'b1; err_data = e;
    while (!err_ready) @(negedge clk);
    @(posedge clk);
    #1 err_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int tot, mn, mx, t0, t1, t2, rdy;
    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 output low in reset", int'(rclk_out), 0);
    rst = 1'b0;
    measure(4, tot, mn, mx);
    check("R1 default half-period total", tot, 8);
    check("R1 default half-period max", mx, 2);

    // table walk: R2 R3 R6 R8
    for (int v = 0; v < NV; v++) begin
      prog(VEC[v][71:64], VEC[v][63:56], VEC[v][55:48], VEC[v][47:40], VEC[v][39:32]);
      measure(int'(VEC[v][31:16]), tot, mn, mx);
      check($sformatf("R2/R3/R6/R8 vector %0d total", v), tot, int'(VEC[v][15:0]));
      check_rng($sformatf("R2 R3 vector %0d interval span", v), mx - mn, 0, 1);
      check_rng($sformatf("R3 vector %0d shortest", v), mn, 2, 300);
    end

    // R4: low byte alone is only staged
    prog(8'd4, 8'h00, 8'h00, 8'd0, 8'h00);
    wr(8'hD5, 8'hFF);
    settle();
    measure(16, tot, mn, mx);
    check("R4 staged low byte no effect total", tot, 64);
    check("R4 staged low byte no effect max", mx, 4);

    // R5: change lands at the next boundary only
    next_edge(t0);
    wr(8'hD7, 8'd8);
    next_edge(t1);
    next_edge(t2);
    check("R5 running half-period kept", t1 - t0, 4);
    check("R5 next half-period uses new factor", t2 - t1, 8);

    // R6: load strobe data is ignored and restores the init value
    prog(8'd4, 8'h00, 8'h00, 8'd64, 8'h10);
    wr(8'hF6, 8'h00);
    settle();
    measure(64, tot, mn, mx);
    check("R6 strobe reload with zero data", tot, 257);

    // R7: ready pacing
    rdy = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (err_ready) rdy++;
    end
    check("R7 ready pulses per 60 cycles", rdy, 10);

    // R7: stream sample accumulates into the phase
    prog(8'd4, 8'h00, 8'h00, 8'd64, 8'h00);
    send_err(8'd16);
    settle();
    measure(64, tot, mn, mx);
    check("R7 accepted sample +16 total", tot, 257);

    // R7: saturation at +127 (100 + 100 -> 127, trim 2032 with gain 16)
    prog(8'd4, 8'h00, 8'h00, 8'd16, 8'd100);
    send_err(8'd100);
    settle();
    measure(64, tot, mn, mx);
    check_rng("R7 positive saturation total", tot, 257, 258);

    // R7: saturation at -128 (-100 - 100 -> -128, trim -2048 with gain 16)
    prog(8'd4, 8'h00, 8'h00, 8'd16, 8'h9C);
    send_err(8'h9C);
    settle();
    measure(64, tot, mn, mx);
    check("R7 negative saturation total", tot, 254);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule